// File: doc/BRIEF.md
# Store Queue with Youngest-Match Load Forwarding

This block keeps pending stores as address/data pairs in a circular buffer, in program order. New stores enter at the tail and leave from the head. A retire pulse moves a boundary pointer forward by one entry. Entries between the head and this boundary are retired. Entries between the boundary and the tail are still speculative. Only retired entries are offered on the commit port. The commit port drains them one per cycle toward data memory, whenever the memory side accepts.

A load presents its address on the lookup port and gets a combinational answer. The block compares the address against every occupied entry. When several entries hold the same address, the block returns the data of the youngest one. When no entry matches, the hit flag is low and the load is expected to read data memory. An entry stays visible to lookups up to and including the cycle in which it is committed.

A partial flush names a slot index and removes every entry younger than that slot. A flush never removes a retired entry: a cut point inside the retired region is moved up to the retire boundary.

Top module: `store_queue_fwd`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `cm_valid` is 0 and `ld_hit` is 0 for any address.
- R2: Stores are committed in the order they were inserted, with `cm_addr`/`cm_data` showing the oldest retired entry.
- R3: When DEPTH entries are occupied, `st_ready` is 0 and a store presented with `st_valid` is dropped (a later lookup of its address misses).
- R4: A lookup whose address matches one or more occupied entries sets `ld_hit` to 1 and returns the data of the most recently inserted match.
- R5: A lookup whose address matches no occupied entry sets `ld_hit` to 0 and `ld_data` to 0, so the load reads data memory instead.
- R6: `cm_valid` is 1 only while at least one retired entry exists. An entry becomes retired only through a `ret_valid` pulse, which retires the oldest speculative entry.
- R7: A `ret_valid` pulse while no speculative entry exists has no effect: a store inserted afterwards is not offered for commit.
- R8: A flush with `fl_valid`=1 and slot `fl_idx` keeps the occupied entries from the head up to and including that slot, and removes all younger entries.
- R9: When the flush slot lies in the retired region, the cut moves to the retire boundary: every retired entry survives and still commits, and every speculative entry is removed.
- R10: A flush naming a slot that holds no occupied entry changes nothing.
- R11: In a cycle with `fl_valid`=1, `st_ready` is 0, and both store insertion and retire are ignored. A commit handshake in that cycle still takes effect.
- R12: An entry committed in a cycle still hits in lookups during that cycle. From the next cycle on it no longer hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store insert request |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Queue can accept a store this cycle |
| ret_valid | input | 1 | Retire the oldest speculative store |
| cm_valid | output | 1 | A retired store is offered for commit |
| cm_addr | output | AW | Address of the store being committed |
| cm_data | output | DW | Data of the store being committed |
| cm_ready | input | 1 | Memory accepts the offered store |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | Load address found in the queue |
| ld_data | output | DW | Data of the youngest matching entry |
| fl_valid | input | 1 | Partial flush request |
| fl_idx | input | log2(DEPTH) | Last slot kept by the flush |

## Verification
The bench builds the queue with DEPTH=4, AW=8 and DW=16. With four entries, the full condition, pointer wrap-around and several duplicate addresses are all reached within a few stores. A flush slot can then be placed in the retired region, in the speculative region, or on an empty slot, all from one short sequence. A small memory array in the bench takes the commit writes, so a load that misses after commit can be checked against the value the drained store left behind.

// File: rtl/sq_pkg.sv
package sq_pkg;

   // Operations the pointer logic actually performs in a cycle
   typedef struct packed {
      logic push;
      logic retire;
      logic pop;
      logic cut;
   } sq_ops_t;

endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
   import sq_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       st_valid,
   input  logic                       ret_valid,
   input  logic                       cm_ready,
   input  logic                       fl_valid,
   input  logic [$clog2(DEPTH)-1:0]   fl_idx,
   output logic [$clog2(DEPTH)-1:0]   head_idx,
   output logic [$clog2(DEPTH)-1:0]   tail_idx,
   output logic [$clog2(DEPTH):0]     occ_cnt,
   output logic [$clog2(DEPTH):0]     ret_cnt,
   output logic                       full,
   output sq_ops_t                    ops
);
   localparam int IW = $clog2(DEPTH);
   localparam int PW = IW + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

   logic [PW-1:0] head_q, ret_q, tail_q;
   logic [PW-1:0] head_n, ret_n, tail_n;
   logic [PW-1:0] spec_cnt;
   logic [IW-1:0] cut_off;
   logic [PW-1:0] cut_keep;
   logic          cut_in_range;
   logic [PW-1:0] cut_tail;

   assign occ_cnt  = tail_q - head_q;
   assign ret_cnt  = ret_q - head_q;
   assign spec_cnt = tail_q - ret_q;
   assign full     = (occ_cnt == DEPTH_P);
   assign head_idx = head_q[IW-1:0];
   assign tail_idx = tail_q[IW-1:0];

   always_comb begin
      ops.cut    = fl_valid;
      ops.push   = st_valid && !full && !fl_valid;
      ops.retire = ret_valid && (spec_cnt != '0) && !fl_valid;
      ops.pop    = cm_ready && (ret_cnt != '0);
   end

   // Flush cut point, measured from the head
   always_comb begin
      cut_off      = fl_idx - head_q[IW-1:0];
      cut_keep     = {1'b0, cut_off} + PW'(1);
      cut_in_range = ({1'b0, cut_off} < occ_cnt);
      cut_tail     = (cut_keep < ret_cnt) ? ret_q : (head_q + cut_keep);
   end

   always_comb begin
      head_n = ops.pop ? head_q + PW'(1) : head_q;
      ret_n  = ops.retire ? ret_q + PW'(1) : ret_q;
      if (ops.cut)
         tail_n = cut_in_range ? cut_tail : tail_q;
      else if (ops.push)
         tail_n = tail_q + PW'(1);
      else
         tail_n = tail_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         ret_q  <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_n;
         ret_q  <= ret_n;
         tail_q <= tail_n;
      end
   end

   generate
      if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
         $error("sq_ctrl: DEPTH must be a power of two and at least 2");
      end
   endgenerate

   // R3: a full queue stays full unless something drains or cuts it
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !ops.pop && !fl_valid) |=> full);

   // R6: the retired region only becomes non-empty after a retire
   assert_commit_after_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ret_cnt != '0) |-> $past(ops.retire));

   // R7: retire with nothing speculative leaves the boundary in place
   assert_retire_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && (spec_cnt == '0) && !fl_valid) |=> (ret_q == $past(ret_q)));

   // R9: a flush keeps the retire boundary and never cuts below it
   assert_flush_keeps_retired_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fl_valid |=> ((ret_q == $past(ret_q)) && (occ_cnt >= ret_cnt)));

endmodule

// File: rtl/sq_slots.sv
module sq_slots #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32
) (
   input  logic                          clk,
   input  logic                          wr_en,
   input  logic [$clog2(DEPTH)-1:0]      wr_idx,
   input  logic [AW-1:0]                 wr_addr,
   input  logic [DW-1:0]                 wr_data,
   output logic [DEPTH-1:0][AW-1:0]      addr_arr,
   output logic [DEPTH-1:0][DW-1:0]      data_arr
);
   localparam int IW = $clog2(DEPTH);

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IW'(s))) begin
               addr_arr[s] <= wr_addr;
               data_arr[s] <= wr_data;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sq_search.sv
module sq_search #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32
) (
   input  logic [DEPTH-1:0][AW-1:0]      addr_arr,
   input  logic [DEPTH-1:0][DW-1:0]      data_arr,
   input  logic [$clog2(DEPTH)-1:0]      head_idx,
   input  logic [$clog2(DEPTH):0]        occ_cnt,
   input  logic [AW-1:0]                 ld_addr,
   output logic                          ld_hit,
   output logic [DW-1:0]                 ld_data
);
   localparam int IW = $clog2(DEPTH);
   localparam int PW = IW + 1;

   // Walk from the youngest position toward the head; first match wins
   always_comb begin
      logic [IW-1:0] slot;
      ld_hit  = 1'b0;
      ld_data = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         slot = head_idx + IW'(k);
         if (!ld_hit && (PW'(k) < occ_cnt) && (addr_arr[slot] == ld_addr)) begin
            ld_hit  = 1'b1;
            ld_data = data_arr[slot];
         end
      end
   end

endmodule

// File: rtl/store_queue_fwd.sv
module store_queue_fwd
   import sq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       st_valid,
   input  logic [AW-1:0]              st_addr,
   input  logic [DW-1:0]              st_data,
   output logic                       st_ready,
   input  logic                       ret_valid,
   output logic                       cm_valid,
   output logic [AW-1:0]              cm_addr,
   output logic [DW-1:0]              cm_data,
   input  logic                       cm_ready,
   input  logic [AW-1:0]              ld_addr,
   output logic                       ld_hit,
   output logic [DW-1:0]              ld_data,
   input  logic                       fl_valid,
   input  logic [$clog2(DEPTH)-1:0]   fl_idx
);
   localparam int IW = $clog2(DEPTH);
   localparam int PW = IW + 1;

   logic [IW-1:0]              head_idx, tail_idx;
   logic [PW-1:0]              occ_cnt, ret_cnt;
   logic                       full;
   sq_ops_t                    ops;
   logic [DEPTH-1:0][AW-1:0]   addr_arr;
   logic [DEPTH-1:0][DW-1:0]   data_arr;

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("store_queue_fwd: AW and DW must be positive");
      end
   endgenerate

   sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .ret_valid(ret_valid), .cm_ready(cm_ready),
      .fl_valid(fl_valid), .fl_idx(fl_idx),
      .head_idx(head_idx), .tail_idx(tail_idx),
      .occ_cnt(occ_cnt), .ret_cnt(ret_cnt), .full(full), .ops(ops)
   );

   sq_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
      .clk(clk), .wr_en(ops.push), .wr_idx(tail_idx),
      .wr_addr(st_addr), .wr_data(st_data),
      .addr_arr(addr_arr), .data_arr(data_arr)
   );

   sq_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
      .addr_arr(addr_arr), .data_arr(data_arr),
      .head_idx(head_idx), .occ_cnt(occ_cnt),
      .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data)
   );

   assign st_ready = !full && !fl_valid;
   assign cm_valid = (ret_cnt != '0);
   assign cm_addr  = addr_arr[head_idx];
   assign cm_data  = data_arr[head_idx];

   // R5: the search never reports a hit on an empty queue
   assert_miss_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_cnt == '0) |-> !ld_hit);

   // R2: an accepted commit advances to the next entry, shrinking the queue
   assert_commit_drains_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && cm_ready && !st_valid && !fl_valid) |=> (occ_cnt == $past(occ_cnt) - PW'(1)));

endmodule

// File: tb/store_queue_fwd_test.sv
module store_queue_fwd_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int IW = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          st_ready;
   logic          ret_valid = 1'b0;
   logic          cm_valid;
   logic [AW-1:0] cm_addr;
   logic [DW-1:0] cm_data;
   logic          cm_ready = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic          ld_hit;
   logic [DW-1:0] ld_data;
   logic          fl_valid = 1'b0;
   logic [IW-1:0] fl_idx = '0;

   logic [DW-1:0] mem [0:255];
   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   store_queue_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
      .ret_valid(ret_valid),
      .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data), .cm_ready(cm_ready),
      .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
      .fl_valid(fl_valid), .fl_idx(fl_idx)
   );

   // Stimulus table: op 0 = store, op 1 = lookup
   localparam int NV = 9;
   localparam int            V_OP   [NV] = '{0, 0, 1, 0, 1, 1, 1, 0, 1};
   localparam logic [AW-1:0] V_ADDR [NV] = '{8'h10, 8'h20, 8'h10, 8'h10, 8'h10, 8'h20, 8'h30, 8'h30, 8'h30};
   localparam logic [DW-1:0] V_DATA [NV] = '{16'h00A1, 16'h00B2, 16'h0, 16'h00C3, 16'h0, 16'h0, 16'h0, 16'h00D4, 16'h0};
   localparam logic          V_HIT  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
   localparam logic [DW-1:0] V_EXP  [NV] = '{16'h0, 16'h0, 16'h00A1, 16'h0, 16'h00C3, 16'h00B2, 16'h0, 16'h0, 16'h00D4};
   localparam string         V_REQ  [NV] = '{"R2", "R2", "R4", "R2", "R4", "R4", "R5", "R2", "R4"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
      st_valid = 1'b1; st_addr = a; st_data = d;
      tick();
      st_valid = 1'b0;
   endtask

   task automatic look(input string req, input logic [AW-1:0] a,
                       input logic exp_hit, input logic [DW-1:0] exp_data);
      ld_addr = a;
      #1;
      check(req, {31'b0, ld_hit}, {31'b0, exp_hit});
      check(req, {16'b0, ld_data}, {16'b0, exp_data});
   endtask

   task automatic retire();
      ret_valid = 1'b1;
      tick();
      ret_valid = 1'b0;
   endtask

   task automatic commit(input string req, input logic [AW-1:0] ea, input logic [DW-1:0] ed);
      check(req, {31'b0, cm_valid}, 32'd1);
      check(req, {24'b0, cm_addr}, {24'b0, ea});
      check(req, {16'b0, cm_data}, {16'b0, ed});
      cm_ready = 1'b1;
      mem[cm_addr] = cm_data;
      tick();
      cm_ready = 1'b0;
   endtask

   task automatic flush(input logic [IW-1:0] idx);
      fl_valid = 1'b1; fl_idx = idx;
      tick();
      fl_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1: reset state
      check("R1 st_ready", {31'b0, st_ready}, 32'd1);
      check("R1 cm_valid", {31'b0, cm_valid}, 32'd0);
      look("R1", 8'h10, 1'b0, 16'h0);

      // Table walk: stores and lookups (R4 youngest match, R5 miss)
      for (int v = 0; v < NV; v++) begin
         if (V_OP[v] == 0) push(V_ADDR[v], V_DATA[v]);
         else look(V_REQ[v], V_ADDR[v], V_HIT[v], V_EXP[v]);
      end

      // R3: full queue refuses a store
      check("R3 st_ready", {31'b0, st_ready}, 32'd0);
      push(8'h40, 16'h00E5);
      look("R3", 8'h40, 1'b0, 16'h0);

      // R6: nothing retired yet
      check("R6 cm_valid", {31'b0, cm_valid}, 32'd0);
      retire();
      retire();

      // R11: flush cycle blocks insert and retire; R9 clamp to boundary
      fl_valid = 1'b1; fl_idx = '0;
      st_valid = 1'b1; st_addr = 8'h50; st_data = 16'h00F6;
      ret_valid = 1'b1;
      #1;
      check("R11 st_ready", {31'b0, st_ready}, 32'd0);
      tick();
      fl_valid = 1'b0; st_valid = 1'b0; ret_valid = 1'b0;
      look("R11", 8'h50, 1'b0, 16'h0);
      look("R9", 8'h30, 1'b0, 16'h0);
      look("R9", 8'h10, 1'b1, 16'h00A1);
      look("R9", 8'h20, 1'b1, 16'h00B2);

      // R12: entry visible during its commit cycle, gone after
      look("R12", 8'h10, 1'b1, 16'h00A1);
      commit("R2", 8'h10, 16'h00A1);
      look("R12", 8'h10, 1'b0, 16'h0);
      check("R12 mem", {16'b0, mem[8'h10]}, 32'h00A1);
      commit("R2", 8'h20, 16'h00B2);
      check("R6 drained", {31'b0, cm_valid}, 32'd0);

      // R7: retire on an empty queue is ignored
      retire();
      push(8'h60, 16'h0067);
      check("R7 cm_valid", {31'b0, cm_valid}, 32'd0);

      // R8: plain flush in speculative region (head slot 2)
      push(8'h70, 16'h0078);
      push(8'h80, 16'h0080);
      flush(2'd3);
      look("R8", 8'h80, 1'b0, 16'h0);
      look("R8", 8'h70, 1'b1, 16'h0078);

      // R10: flush naming an empty slot has no effect
      flush(2'd1);
      look("R10", 8'h70, 1'b1, 16'h0078);
      look("R10", 8'h60, 1'b1, 16'h0067);

      // Wrap-around store, then drain in order (R2)
      push(8'h90, 16'h0099);
      look("R4 wrap", 8'h90, 1'b1, 16'h0099);
      retire(); retire(); retire();
      commit("R2", 8'h60, 16'h0067);
      commit("R2", 8'h70, 16'h0078);
      commit("R2", 8'h90, 16'h0099);
      check("R2 empty", {31'b0, cm_valid}, 32'd0);
      look("R5 empty", 8'h90, 1'b0, 16'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule